// File: doc/BRIEF.md
# Receive Byte Queue with Fill-Level Alert

This block holds the bytes that a serial-bus engine has taken off the wire until host software collects them. The engine offers one byte per cycle on a push strobe. The host removes bytes one at a time with a read strobe and sees them in the order they arrived. The host can also read a zero-based fill count, an empty flag and a full flag.

The host programs a zero-based alert level. While the queue holds more bytes than that level, a level-type alert is raised. A driver that expects a known number of bytes sets the level to that number minus one, capped at the top value. When the alert fires, the whole expected group can be drained at once. The level may be lowered between reads as the remaining count shrinks. A synchronous flush empties the queue in one cycle when the controller is reset.

Top module: `rxq_fifo`

## Requirements
- R1: After a synchronous reset, the outputs read as follows: `empty`=1, `full`=0, `occ_rdata`=0, `thr_rdata`=DEPTH-1 (15 by default), `rx_full_irq`=0, `ovf_sticky`=0 and `rd_data`=0.
- R2: An accepted push stores one byte. While at least one byte is stored, `occ_rdata` reads the stored count minus one, so a full 16-entry queue reads 15.
- R3: With nothing stored, `occ_rdata` reads 0. Only `empty`=1 tells this case apart from one stored byte.
- R4: Each read strobe on a non-empty queue removes the oldest byte and presents it on `rd_data` from the following cycle. A read strobe on an empty queue leaves `rd_data` and the fill count unchanged.
- R5: `empty` is 1 exactly when no byte is stored. `full` is 1 exactly when DEPTH bytes are stored.
- R6: `rx_full_irq` is 1 whenever the stored count is at least the alert level plus one. It follows every change of count or level with no extra delay.
- R7: A push is dropped whenever the queue is full at the start of that cycle, even if a read strobe comes in the same cycle (the read still proceeds). A dropped push sets `ovf_sticky`, which stays set until a flush or a reset.
- R8: A flush empties the queue in one cycle and clears `ovf_sticky`. Any push or read strobe in that same cycle is ignored. The flush leaves `rd_data` and the alert level untouched.
- R9: A write strobe loads the alert level from `thr_wdata` (range 0 to DEPTH-1). `thr_rdata` shows the new value from the next cycle.
- R10: A push and a read strobe in the same cycle on a queue that is neither empty nor full leave the count unchanged and keep arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous queue flush |
| push_valid | input | 1 | Engine offers a received byte |
| push_data | input | DATA_W | Received byte |
| pop_strobe | input | 1 | Host read of the data register |
| rd_data | output | DATA_W | Last byte removed (registered) |
| thr_wr | input | 1 | Host write of the alert level |
| thr_wdata | input | $clog2(DEPTH) | New zero-based alert level |
| thr_rdata | output | $clog2(DEPTH) | Current alert level |
| occ_rdata | output | $clog2(DEPTH) | Stored count minus one (0 when empty) |
| empty | output | 1 | No byte stored |
| full | output | 1 | DEPTH bytes stored |
| rx_full_irq | output | 1 | Level alert: count above alert level |
| ovf_sticky | output | 1 | A push was dropped on a full queue |

## Verification
The bench builds the block with its default parameters: DEPTH=16 and DATA_W=8. With these values a queue can be filled to the top within a few dozen cycles. That puts the wrap of both pointers, the highest alert level of 15, the drop of a push on a full queue, and the 0-versus-1 ambiguity of the zero-based count all within reach of short directed sequences. The 8-bit data lets each stored byte carry a distinct tag, so any loss or reordering shows up in the drained values.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // qualified per-cycle operations handed from the pointer logic to storage
  typedef struct packed {
    logic wr;
    logic rd;
  } rxq_op_t;
endpackage

// File: rtl/rxq_mem.sv
module rxq_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  rxq_pkg::rxq_op_t  op,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // write port: no reset so the array maps onto block RAM
  always_ff @(posedge clk) begin
    if (op.wr) mem[waddr] <= wdata;
  end

  // registered read port, read-first on a shared address
  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (op.rd) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  output rxq_pkg::rxq_op_t op,
  output logic [AW-1:0]    wptr,
  output logic [AW-1:0]    rptr,
  output logic [CW-1:0]    count,
  output logic             overflow
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic is_full, is_empty;
  assign is_full  = (count == FULL_CNT);
  assign is_empty = (count == '0);

  always_comb begin
    op.wr = push && !flush && !is_full;
    op.rd = pop  && !flush && !is_empty;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (op.wr) wptr <= wptr + AW'(1);
      if (op.rd) rptr <= rptr + AW'(1);
      unique case ({op.wr, op.rd})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
      if (push && is_full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          thr_wr,
  input  logic [AW-1:0] thr_wdata,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] thr_q,
  output logic          hit
);
  always_ff @(posedge clk) begin
    if (rst)         thr_q <= AW'(DEPTH - 1);
    else if (thr_wr) thr_q <= thr_wdata;
  end

  // count >= thr+1 is the same as count > thr
  assign hit = (count > {1'b0, thr_q});
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_strobe,
  output logic [DATA_W-1:0] rd_data,
  input  logic              thr_wr,
  input  logic [AW-1:0]     thr_wdata,
  output logic [AW-1:0]     thr_rdata,
  output logic [AW-1:0]     occ_rdata,
  output logic              empty,
  output logic              full,
  output logic              rx_full_irq,
  output logic              ovf_sticky
);
  rxq_pkg::rxq_op_t op;
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;

  rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .flush(flush),
    .push(push_valid), .pop(pop_strobe),
    .op(op), .wptr(wptr), .rptr(rptr),
    .count(count), .overflow(ovf_sticky)
  );

  rxq_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst(rst), .op(op),
    .waddr(wptr), .wdata(push_data),
    .raddr(rptr), .rdata(rd_data)
  );

  rxq_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst(rst),
    .thr_wr(thr_wr), .thr_wdata(thr_wdata),
    .count(count), .thr_q(thr_rdata), .hit(rx_full_irq)
  );

  // all status is decoded from registered state only
  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign occ_rdata = empty ? '0 : AW'(count - CW'(1));
endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              push_valid,
  input logic              pop_strobe,
  input logic [DATA_W-1:0] rd_data,
  input logic              thr_wr,
  input logic [AW-1:0]     thr_wdata,
  input logic [AW-1:0]     thr_rdata,
  input logic [AW-1:0]     occ_rdata,
  input logic              empty,
  input logic              full,
  input logic              rx_full_irq,
  input logic              ovf_sticky
);
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  a_r3_empty_reads_zero: assert property (@(posedge clk) disable iff (rst)
    empty |-> (occ_rdata == '0));

  a_r6_full_implies_alert: assert property (@(posedge clk) disable iff (rst)
    full |-> rx_full_irq);

  a_r2_push_counts_up: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !pop_strobe && !flush && !full && !empty)
      |=> (occ_rdata == $past(occ_rdata) + AW'(1)));

  a_r4_read_data_held: assert property (@(posedge clk) disable iff (rst)
    !(pop_strobe && !empty && !flush) |=> $stable(rd_data));

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_sticky && !flush) |=> ovf_sticky);

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (empty && !ovf_sticky && !rx_full_irq));

  a_r9_level_loads: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> (thr_rdata == $past(thr_wdata)));
endmodule

bind rxq_fifo rxq_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .flush(flush),
  .push_valid(push_valid), .pop_strobe(pop_strobe), .rd_data(rd_data),
  .thr_wr(thr_wr), .thr_wdata(thr_wdata), .thr_rdata(thr_rdata),
  .occ_rdata(occ_rdata), .empty(empty), .full(full),
  .rx_full_irq(rx_full_irq), .ovf_sticky(ovf_sticky)
);

// File: tb/rxq_fifo_tb.sv
`timescale 1ns/1ps
module rxq_fifo_tb;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int AW     = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst, flush, push_valid, pop_strobe, thr_wr;
  logic [DATA_W-1:0] push_data, rd_data;
  logic [AW-1:0] thr_wdata, thr_rdata, occ_rdata;
  logic empty, full, rx_full_irq, ovf_sticky;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rxq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .flush(flush),
    .push_valid(push_valid), .push_data(push_data),
    .pop_strobe(pop_strobe), .rd_data(rd_data),
    .thr_wr(thr_wr), .thr_wdata(thr_wdata), .thr_rdata(thr_rdata),
    .occ_rdata(occ_rdata), .empty(empty), .full(full),
    .rx_full_irq(rx_full_irq), .ovf_sticky(ovf_sticky)
  );

  typedef struct packed {
    logic       push;
    logic [7:0] d;
    logic       pop;
    logic       twr;
    logic [3:0] tv;
    logic [3:0] occ;
    logic       emp;
    logic       ful;
    logic       irq;
    logic       chk;
    logic [7:0] rd;
  } vec_t;

  // state expected after each row's clock edge
  localparam vec_t VEC [14] = '{
    '{1'b0, 8'h00, 1'b0, 1'b1, 4'd2, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    '{1'b1, 8'hA1, 1'b0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{1'b1, 8'hA2, 1'b0, 1'b0, 4'd0, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{1'b1, 8'hA3, 1'b0, 1'b0, 4'd0, 4'd2, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b1, 1'b0, 4'd0, 4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA1},
    '{1'b1, 8'hA4, 1'b1, 1'b0, 4'd0, 4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA2},
    '{1'b0, 8'h00, 1'b0, 1'b1, 4'd1, 4'd1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b1, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA3},
    '{1'b0, 8'h00, 1'b1, 1'b0, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA4},
    '{1'b0, 8'h00, 1'b1, 1'b0, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA4},
    '{1'b0, 8'h00, 1'b0, 1'b1, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    '{1'b1, 8'hB0, 1'b0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    '{1'b1, 8'hB1, 1'b1, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hB0},
    '{1'b0, 8'h00, 1'b1, 1'b0, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hB1}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // called at a falling edge; returns at the next falling edge with inputs idle
  task automatic cyc(input logic p, input logic [7:0] d, input logic r,
                     input logic tw, input logic [3:0] tv, input logic fl);
    push_valid = p; push_data = d; pop_strobe = r;
    thr_wr = tw; thr_wdata = tv; flush = fl;
    @(negedge clk);
    push_valid = 1'b0; pop_strobe = 1'b0; thr_wr = 1'b0; flush = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check_reset_state();
    check("R1", "empty", empty, 1);
    check("R1", "full", full, 0);
    check("R1", "occ", occ_rdata, 0);
    check("R1", "thr", thr_rdata, DEPTH - 1);
    check("R1", "irq", rx_full_irq, 0);
    check("R1", "ovf", ovf_sticky, 0);
    check("R1", "rd_data", rd_data, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; flush = 1'b0; push_valid = 1'b0; pop_strobe = 1'b0;
    thr_wr = 1'b0; push_data = '0; thr_wdata = '0;
    @(negedge clk);
    do_reset();
    check_reset_state();

    // table walk: R2 R3 R4 R6 R9 R10
    for (int i = 0; i < 14; i++) begin
      cyc(VEC[i].push, VEC[i].d, VEC[i].pop, VEC[i].twr, VEC[i].tv, 1'b0);
      check("R2", $sformatf("row%0d occ", i), occ_rdata, VEC[i].occ);
      check("R3", $sformatf("row%0d empty", i), empty, VEC[i].emp);
      check("R5", $sformatf("row%0d full", i), full, VEC[i].ful);
      check("R6", $sformatf("row%0d irq", i), rx_full_irq, VEC[i].irq);
      if (VEC[i].chk) check("R4", $sformatf("row%0d rd_data", i), rd_data, VEC[i].rd);
    end
    check("R9", "thr after table", thr_rdata, 0);

    // fill to the top with level 0
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 8'h10 + 8'(i), 1'b0, 1'b0, 4'd0, 1'b0);
    check("R5", "full after fill", full, 1);
    check("R2", "occ when full", occ_rdata, DEPTH - 1);
    check("R6", "irq when full", rx_full_irq, 1);
    check("R7", "no overflow yet", ovf_sticky, 0);

    // push on full is dropped
    cyc(1'b1, 8'hEE, 1'b0, 1'b0, 4'd0, 1'b0);
    check("R7", "overflow set", ovf_sticky, 1);
    check("R7", "occ unchanged", occ_rdata, DEPTH - 1);

    // push with pop on full: pop proceeds, push dropped
    cyc(1'b1, 8'hDD, 1'b1, 1'b0, 4'd0, 1'b0);
    check("R7", "pop on full data", rd_data, 8'h10);
    check("R7", "occ after pop on full", occ_rdata, DEPTH - 2);
    check("R5", "not full", full, 0);

    // drain: arrival order, dropped bytes absent
    for (int i = 1; i < DEPTH; i++) begin
      cyc(1'b0, 8'h00, 1'b1, 1'b0, 4'd0, 1'b0);
      check("R4", $sformatf("drain %0d", i), rd_data, 8'h10 + 8'(i));
    end
    check("R7", "empty after drain", empty, 1);
    check("R7", "overflow still set", ovf_sticky, 1);

    // highest level
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 4'd15, 1'b0);
    check("R9", "thr 15", thr_rdata, 15);
    for (int i = 0; i < DEPTH - 1; i++) cyc(1'b1, 8'h40 + 8'(i), 1'b0, 1'b0, 4'd0, 1'b0);
    check("R6", "15 stored level 15", rx_full_irq, 0);
    cyc(1'b1, 8'h4F, 1'b0, 1'b0, 4'd0, 1'b0);
    check("R6", "16 stored level 15", rx_full_irq, 1);

    // flush with concurrent push and pop
    cyc(1'b1, 8'h77, 1'b1, 1'b0, 4'd0, 1'b1);
    check("R8", "empty after flush", empty, 1);
    check("R8", "ovf cleared", ovf_sticky, 0);
    check("R8", "rd_data held", rd_data, 8'h1F);
    check("R8", "thr kept", thr_rdata, 15);
    check("R8", "irq low", rx_full_irq, 0);

    // queue usable after flush
    cyc(1'b1, 8'h5A, 1'b0, 1'b0, 4'd0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 4'd0, 1'b0);
    check("R8", "first byte after flush", rd_data, 8'h5A);
    check("R3", "empty again", empty, 1);

    // reset in mid-run
    cyc(1'b1, 8'h33, 1'b0, 1'b1, 4'd3, 1'b0);
    do_reset();
    check_reset_state();

    summary();
    $finish;
  end
endmodule